// File: doc/BRIEF.md
# Deep Sleep Watchdog Timer

This block is a watchdog that runs only while the chip sits in its deepest low-power state. If the sleep lasts longer than a programmed period, the block wakes the chip. The count is kept in a free-running fast clock domain (`clk`). The slow oscillator that times the sleep reaches the block as single-cycle tick strobes, together with a "running" flag for that oscillator. Two slow sources exist: a secondary crystal oscillator (source 0) and an internal low-power RC oscillator (source 1). One static select bit picks which of them is counted.

The watchdog has its own enable and does not depend on any other watchdog. Each time deep sleep begins, the count restarts from zero. While the chip is in deep sleep with the watchdog enabled, the block raises a request line to the selected oscillator, so an oscillator that was off is started without software action. Ticks are counted only once that oscillator reports that it is running. When the count reaches the terminal value chosen by a 4-bit period field, the block emits a one-cycle wake pulse and sets a sticky flag. The flag stays set until the next entry into deep sleep or a power-on reset.

All configuration arrives as static pins. There is no register bus and no data stream; every pin is a plain control or status line.

Top module: `sleep_wdog`

## Requirements
- R1: While `por_n` is low, and right after it is released, `wake_pulse` and `timeout_flag` are 0, and each request line equals its own keep input.
- R2: With the block enabled, in deep sleep and the selected oscillator running, `wake_pulse` rises on the cycle after the terminal tick is sampled. The terminal tick is the 2^(6+2k)-th tick of the selected source, where k is the unsigned value of `period_sel`.
- R3: The period field decodes so that k=0 needs 64 ticks, k=1 needs 256 ticks and k=2 needs 1024 ticks. Each step of k multiplies the period by four.
- R4: `wake_pulse` lasts exactly one cycle. `timeout_flag` rises together with it and stays 1, including after deep sleep ends. No further wake pulse occurs until the next entry into deep sleep.
- R5: A rising edge of `sleep_active` clears both the tick count and `timeout_flag`.
- R6: While `sleep_active` is 0, the count is held at zero. Ticks received before leaving deep sleep are discarded, so a later sleep again needs the full period.
- R7: `sosc_req` is 1 when (`wdt_en` and `sleep_active` and `src_sel`=0) or `sosc_keep`. `lprc_req` is 1 when (`wdt_en` and `sleep_active` and `src_sel`=1) or `lprc_keep`. Both are combinational.
- R8: Ticks are ignored while the selected source's ready input is 0. Ready passes a 2-stage synchronizer, so ticks are counted from the third clock edge after ready rises.
- R9: Ticks on the source that is not selected have no effect on the count.
- R10: With `wdt_en` = 0, no tick is counted, no wake pulse occurs, and no request is raised except through the keep inputs.
- R11: An asynchronous low pulse on `por_n` clears the count, the flag and the synchronizers at once, even in the middle of a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that hosts all state |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wdt_en | input | 1 | Static enable of this watchdog |
| period_sel | input | 4 | Static period select k; terminal count is 2^(6+2k) ticks |
| src_sel | input | 1 | Static clock source select: 0 crystal, 1 RC |
| sleep_active | input | 1 | High while the chip is in deep sleep |
| sosc_tick | input | 1 | One-cycle strobe per crystal oscillator period |
| lprc_tick | input | 1 | One-cycle strobe per RC oscillator period |
| sosc_ready | input | 1 | Crystal oscillator is running (asynchronous) |
| lprc_ready | input | 1 | RC oscillator is running (asynchronous) |
| sosc_keep | input | 1 | Another client needs the crystal oscillator |
| lprc_keep | input | 1 | Another client needs the RC oscillator |
| sosc_req | output | 1 | Run request to the crystal oscillator |
| lprc_req | output | 1 | Run request to the RC oscillator |
| wake_pulse | output | 1 | One-cycle time-out wake event |
| timeout_flag | output | 1 | Sticky time-out indication |

## Verification
The bench counts the ticks it delivers and checks on which tick the wake pulse first appears. A terminal compare that is off by one, or a wrong shift per period step, moves that tick and is reported. Ticks are sent while the oscillator is not ready and on the source that is not selected. A design that ignores ready or mixes up the sources wakes too early. The bench also leaves deep sleep partway through a count and then re-enters; a counter that keeps its progress wakes after fewer than the full period of ticks. Finally, a power-on reset is applied partway through a count and after a time-out. A flag that survives the reset, or a pulse that lasts more than one cycle, is caught at the outputs.

// File: rtl/sleep_wdog_pkg.sv
package sleep_wdog_pkg;

  // Clock source encoding of the select input
  typedef enum logic {
    SRC_XTAL = 1'b0,
    SRC_RC   = 1'b1
  } wd_src_e;

  localparam int unsigned NUM_SRC = 2;

  // Shift amount for a period code: base + step * code
  function automatic int unsigned wd_shift(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned code);
    return base + step * code;
  endfunction

endpackage

// File: rtl/sleep_wdog_entry.sv
module sleep_wdog_entry (
  input  logic clk,
  input  logic por_n,
  input  logic sleep_i,
  output logic entry_o
);

  logic sleep_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sleep_q <= 1'b0;
    else        sleep_q <= sleep_i;
  end

  assign entry_o = sleep_i & ~sleep_q;

  AST_ENTRY_ONE_SHOT: assert property (@(posedge clk) disable iff (!por_n)
    entry_o |=> !entry_o); // R5

endmodule

// File: rtl/sleep_wdog_clkmux.sv
module sleep_wdog_clkmux #(
  parameter int unsigned NSRC  = 2,
  parameter int unsigned SYNC  = 2,
  localparam int unsigned SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            active_i,
  input  logic [SW-1:0]   sel_i,
  input  logic [NSRC-1:0] tick_i,
  input  logic [NSRC-1:0] ready_i,
  input  logic [NSRC-1:0] keep_i,
  output logic [NSRC-1:0] req_o,
  output logic            tick_o,
  output logic            ready_o
);

  logic [NSRC-1:0] ready_s;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [SYNC-1:0] shr;

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) shr <= '0;
      else        shr <= {shr[SYNC-2:0], ready_i[g]};
    end

    assign ready_s[g] = shr[SYNC-1];
    assign req_o[g]   = (active_i && (sel_i == SW'(g))) || keep_i[g];
  end

  assign tick_o  = tick_i[sel_i];
  assign ready_o = ready_s[sel_i];

  AST_READY_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!por_n)
    (ready_o && $stable(sel_i) && !$past(ready_o)) |-> $past(ready_i[sel_i])); // R8

endmodule

// File: rtl/sleep_wdog_counter.sv
module sleep_wdog_counter
  import sleep_wdog_pkg::*;
#(
  parameter int unsigned SEL_W = 4,
  parameter int unsigned BASE  = 6,
  parameter int unsigned STEP  = 2,
  localparam int unsigned NCODE = 1 << SEL_W,
  localparam int unsigned CNT_W = BASE + STEP * (NCODE - 1) + 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             entry_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             ready_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             wake_o,
  output logic             flag_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] term;
  logic             flag_q;
  logic             wake_q;
  logic             cnt_en;
  logic             hit;

  always_comb begin
    term = CNT_W'(1) << wd_shift(BASE, STEP, 32'(sel_i));
  end

  assign cnt_en = run_i && ready_i && tick_i && !flag_q && !entry_i;
  assign cnt_nx = cnt_q + CNT_W'(1);
  assign hit    = (cnt_nx == term);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      wake_q <= 1'b0;
    end else if (entry_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      wake_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      wake_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_nx;
      wake_q <= hit;
      if (hit) flag_q <= 1'b1;
    end else begin
      wake_q <= 1'b0;
    end
  end

  assign wake_o = wake_q;
  assign flag_o = flag_q;

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    wake_q |=> !wake_q); // R4
  AST_WAKE_SETS_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    wake_q |-> flag_q); // R4
  AST_FROZEN_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!por_n)
    (flag_q && run_i && !entry_i) |=> $stable(cnt_q)); // R4
  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    entry_i |=> (cnt_q == '0 && !flag_q)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    !run_i |=> (cnt_q == '0)); // R6
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (run_i && !entry_i && (!tick_i || !ready_i)) |=> $stable(cnt_q)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!por_n)
    cnt_q <= term); // R2

endmodule

// File: rtl/sleep_wdog.sv
module sleep_wdog
  import sleep_wdog_pkg::*;
#(
  parameter int unsigned SEL_W = 4,
  parameter int unsigned BASE  = 6,
  parameter int unsigned STEP  = 2,
  parameter int unsigned SYNC  = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wdt_en,
  input  logic [SEL_W-1:0] period_sel,
  input  logic             src_sel,
  input  logic             sleep_active,
  input  logic             sosc_tick,
  input  logic             lprc_tick,
  input  logic             sosc_ready,
  input  logic             lprc_ready,
  input  logic             sosc_keep,
  input  logic             lprc_keep,
  output logic             sosc_req,
  output logic             lprc_req,
  output logic             wake_pulse,
  output logic             timeout_flag
);

  logic               entry;
  logic               run;
  logic               tick_sel;
  logic               ready_sel;
  logic [NUM_SRC-1:0] req_v;

  assign run = wdt_en && sleep_active;

  sleep_wdog_entry u_entry (
    .clk     (clk),
    .por_n   (por_n),
    .sleep_i (sleep_active),
    .entry_o (entry)
  );

  sleep_wdog_clkmux #(
    .NSRC (NUM_SRC),
    .SYNC (SYNC)
  ) u_mux (
    .clk      (clk),
    .por_n    (por_n),
    .active_i (run),
    .sel_i    (src_sel),
    .tick_i   ({lprc_tick, sosc_tick}),
    .ready_i  ({lprc_ready, sosc_ready}),
    .keep_i   ({lprc_keep, sosc_keep}),
    .req_o    (req_v),
    .tick_o   (tick_sel),
    .ready_o  (ready_sel)
  );

  sleep_wdog_counter #(
    .SEL_W (SEL_W),
    .BASE  (BASE),
    .STEP  (STEP)
  ) u_cnt (
    .clk     (clk),
    .por_n   (por_n),
    .entry_i (entry),
    .run_i   (run),
    .tick_i  (tick_sel),
    .ready_i (ready_sel),
    .sel_i   (period_sel),
    .wake_o  (wake_pulse),
    .flag_o  (timeout_flag)
  );

  assign sosc_req = req_v[SRC_XTAL];
  assign lprc_req = req_v[SRC_RC];

  AST_DISABLED_NO_WAKE: assert property (@(posedge clk) disable iff (!por_n)
    (!wdt_en && !$past(wdt_en)) |-> !wake_pulse); // R10
  AST_DISABLED_NO_REQ: assert property (@(posedge clk) disable iff (!por_n)
    (!wdt_en && !sosc_keep && !lprc_keep) |-> (!sosc_req && !lprc_req)); // R10
  AST_ASLEEP_REQUESTS: assert property (@(posedge clk) disable iff (!por_n)
    run |-> (src_sel ? lprc_req : sosc_req)); // R7

endmodule

// File: tb/sleep_wdog_bench.sv
`timescale 1ns/1ps
module sleep_wdog_bench;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       wdt_en = 1'b0;
  logic [3:0] period_sel = 4'd0;
  logic       src_sel = 1'b0;
  logic       sleep_active = 1'b0;
  logic       sosc_tick = 1'b0, lprc_tick = 1'b0;
  logic       sosc_ready = 1'b0, lprc_ready = 1'b0;
  logic       sosc_keep = 1'b0, lprc_keep = 1'b0;
  logic       sosc_req, lprc_req, wake_pulse, timeout_flag;

  int checks = 0;
  int errors = 0;
  int first_wake;
  int wake_cycles;

  always #4 clk = ~clk;

  sleep_wdog u_sleep_wdog (
    .clk(clk), .por_n(por_n), .wdt_en(wdt_en), .period_sel(period_sel),
    .src_sel(src_sel), .sleep_active(sleep_active),
    .sosc_tick(sosc_tick), .lprc_tick(lprc_tick),
    .sosc_ready(sosc_ready), .lprc_ready(lprc_ready),
    .sosc_keep(sosc_keep), .lprc_keep(lprc_keep),
    .sosc_req(sosc_req), .lprc_req(lprc_req),
    .wake_pulse(wake_pulse), .timeout_flag(timeout_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Deliver n ticks on a source, one per two cycles; record wake behaviour
  task automatic send_ticks(input int n, input bit on_rc);
    first_wake  = 0;
    wake_cycles = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (wake_pulse) wake_cycles++;
      if (on_rc) lprc_tick = 1'b1; else sosc_tick = 1'b1;
      @(negedge clk);
      sosc_tick = 1'b0;
      lprc_tick = 1'b0;
      if (wake_pulse) begin
        wake_cycles++;
        if (first_wake == 0) first_wake = i;
      end
    end
    repeat (2) begin
      @(negedge clk);
      if (wake_pulse) wake_cycles++;
    end
  endtask

  task automatic go_sleep(input bit src, input logic [3:0] k);
    @(negedge clk);
    sleep_active = 1'b0;
    wdt_en = 1'b1;
    src_sel = src;
    period_sel = k;
    sosc_ready = 1'b1;
    lprc_ready = 1'b1;
    repeat (4) @(negedge clk);
    sleep_active = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic leave_sleep();
    @(negedge clk);
    sleep_active = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    sosc_keep = 1'b1;
    #1;
    check("R1 wake in reset", int'(wake_pulse), 0);
    check("R1 flag in reset", int'(timeout_flag), 0);
    check("R1 sosc_req follows keep", int'(sosc_req), 1);
    check("R1 lprc_req follows keep", int'(lprc_req), 0);
    sosc_keep = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 flag after release", int'(timeout_flag), 0);
  endtask

  task automatic t_requests();
    @(negedge clk);
    wdt_en = 1'b1; src_sel = 1'b0; sleep_active = 1'b1; #1;
    check("R7 sosc_req asleep src0", int'(sosc_req), 1);
    check("R7 lprc_req asleep src0", int'(lprc_req), 0);
    src_sel = 1'b1; #1;
    check("R7 lprc_req asleep src1", int'(lprc_req), 1);
    check("R7 sosc_req asleep src1", int'(sosc_req), 0);
    sleep_active = 1'b0; #1;
    check("R7 no req when awake", int'(lprc_req | sosc_req), 0);
    lprc_keep = 1'b1; #1;
    check("R7 keep holds lprc_req", int'(lprc_req), 1);
    lprc_keep = 1'b0;
    wdt_en = 1'b0; sleep_active = 1'b1; #1;
    check("R10 no req when disabled", int'(lprc_req | sosc_req), 0);
    @(negedge clk);
    sleep_active = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_period(input logic [3:0] k, input int term);
    go_sleep(1'b0, k);
    send_ticks(term + 3, 1'b0);
    check("R2 R3 wake tick index", first_wake, term);
    check("R4 wake lasts one cycle", wake_cycles, 1);
    check("R4 flag set", int'(timeout_flag), 1);
    leave_sleep();
    check("R4 flag sticky after exit", int'(timeout_flag), 1);
  endtask

  task automatic t_reentry_clears();
    go_sleep(1'b0, 4'd0);
    check("R5 flag cleared by entry", int'(timeout_flag), 0);
    send_ticks(40, 1'b0);
    leave_sleep();
    go_sleep(1'b0, 4'd0);
    send_ticks(70, 1'b0);
    check("R6 full period after re-entry", first_wake, 64);
    send_ticks(100, 1'b0);
    check("R4 no second wake", wake_cycles, 0);
    leave_sleep();
  endtask

  task automatic t_not_ready();
    @(negedge clk);
    sosc_ready = 1'b0;
    lprc_ready = 1'b0;
    wdt_en = 1'b1; src_sel = 1'b0; period_sel = 4'd0;
    repeat (4) @(negedge clk);
    sleep_active = 1'b1;
    repeat (2) @(negedge clk);
    send_ticks(100, 1'b0);
    check("R8 ticks ignored before ready", wake_cycles, 0);
    sosc_ready = 1'b1;
    repeat (4) @(negedge clk);
    send_ticks(70, 1'b0);
    check("R8 count starts after ready", first_wake, 64);
    leave_sleep();
  endtask

  task automatic t_unselected();
    go_sleep(1'b1, 4'd0);
    send_ticks(100, 1'b0);
    check("R9 other source ignored", wake_cycles, 0);
    send_ticks(70, 1'b1);
    check("R9 selected source counted", first_wake, 64);
    leave_sleep();
  endtask

  task automatic t_disabled();
    go_sleep(1'b0, 4'd0);
    @(negedge clk);
    wdt_en = 1'b0;
    #1;
    check("R10 disabled sosc_req", int'(sosc_req), 0);
    send_ticks(150, 1'b0);
    check("R10 disabled no wake", wake_cycles, 0);
    leave_sleep();
    wdt_en = 1'b1;
  endtask

  task automatic t_por();
    go_sleep(1'b0, 4'd0);
    send_ticks(70, 1'b0);
    check("R11 flag before reset", int'(timeout_flag), 1);
    #3 por_n = 1'b0;
    #1;
    check("R11 flag cleared asynchronously", int'(timeout_flag), 0);
    @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    send_ticks(40, 1'b0);
    #3 por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    send_ticks(70, 1'b0);
    check("R11 count restarts after reset", first_wake, 64);
    leave_sleep();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_requests();
    t_period(4'd0, 64);
    t_period(4'd1, 256);
    t_period(4'd2, 1024);
    t_reentry_clears();
    t_not_ready();
    t_unselected();
    t_disabled();
    t_por();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule